// File: doc/BRIEF.md
# Serial Control Register Port

This block is the register-programming front end of a converter's clock and data-format logic. An external controller drives four wires: an active-low latch, a serial clock, a data-in line and a tri-stated data-out line. While the latch is low the controller shifts in one 24-bit word, MSB first. Byte 0 holds a 7-bit chip identity (0x04) in bits 7:1 and a direction flag in bit 0 (0 = write, 1 = read). Byte 1 selects a register. Byte 2 carries the write data, or is the slot in which the block returns the read data. The register values go to the rest of the chip through a flat output bus.

The four serial pins are oversampled in the system clock domain through synchroniser chains. The serial clock therefore needs no phase or frequency relation to the system clock. It must be slow enough that each of its half periods lasts at least four system clocks. Once reset is released, the block waits for the synchronisers to settle and then samples the pins a single time. If the latch, serial clock and data-in are all low at that moment, the block enters a pin-strapped standalone configuration. In that configuration serial frames are ignored, the master-clock enable is forced on, and the level on the data-out pad selects whether the serial data clocks run as master or slave. All other registers keep their defaults, which give stereo, I2S format and a 256x master clock.

Top module: `ctrl_spi_regport`

## Requirements
- R1: After reset, with the latch high at the strap sample, `regs_o` equals `RST_VAL` (default 32'h1000_0000, register n at bits 8n+7:8n), `standalone_o` is 0 and `ser_dout_oe` is 0.
- R2: A frame of exactly 24 bits with byte 0 = 0x08 writes byte 2 into the register selected by byte 1 when the latch returns high.
- R3: A frame whose byte 0 bits 7:1 differ from 0x04 changes no register and never enables data-out.
- R4: A write frame of any length other than 24 bits (for example 23 or 25) changes no register.
- R5: A frame with byte 0 = 0x09 returns the selected register MSB first during the third byte. Each bit is driven after a falling serial clock edge and is valid at the next rising edge. `ser_dout_oe` stays 0 during bytes 0 and 1 and after the latch returns high. The read does not change any register.
- R6: Register addresses at or above `NREGS` are not writable, and reading them returns 0x00.
- R7: With latch, serial clock and data-in all low at the strap sample, `standalone_o` becomes 1. `regs_o` then holds `RST_VAL`, except that register 0 bit 0 (master-clock enable) is 1 and register 2 bit 0 (1 = master) equals the data-out pad level.
- R8: In standalone mode, frames change no register and `ser_dout_oe` stays 0.
- R9: `regs_o` changes only in the cycle after a committed write or after the strap sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_latch_n | input | 1 | Frame latch, active low |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data in |
| ser_dout_pad | input | 1 | Level seen on the data-out pad (strap input at boot) |
| ser_dout | output | 1 | Serial data out value |
| ser_dout_oe | output | 1 | Data-out drive enable |
| regs_o | output | NREGS*8 | Register file contents |
| standalone_o | output | 1 | Standalone mode flag |

## Verification
Some rules are checked by assertions on every cycle. Data-out is never driven during boot, in standalone mode, or once the latch has risen. The mode flag cannot change after the strap sample. The forced clock enable holds throughout standalone mode. Registers change only after a write strobe or the boot sample. The bench scenarios are what show the data behaviour: frame decoding, the exact bit count, chip-identity filtering, the MSB-first read bytes and address bounds, and the two strap levels.

// File: rtl/ctrl_spi_pkg.sv
package ctrl_spi_pkg;
    localparam int          REG_W      = 8;
    localparam logic [6:0]  CHIP_ID    = 7'h04;
    localparam int          FRAME_BITS = 24;
    localparam int          HDR_BITS   = 16;
    localparam int          CLK_REG    = 0;  // master-clock control register
    localparam int          MCLK_BIT   = 0;  // master-clock enable
    localparam int          PORT_REG   = 2;  // serial data port register
    localparam int          MASTER_BIT = 0;  // 1 = port drives its clocks
endpackage

// File: rtl/ctrl_spi_sync.sv
module ctrl_spi_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctrl_spi_strap.sv
module ctrl_spi_strap #(
    parameter int BOOT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_s,
    input  logic sclk_s,
    input  logic lat_s,
    input  logic pad_s,
    output logic boot_pulse_o,
    output logic boot_done_o,
    output logic sa_now_o,
    output logic strap_now_o,
    output logic standalone_o
);
    localparam int CW = $clog2(BOOT_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          standalone;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        boot_pulse_o = (st_q.cnt == CW'(BOOT_CYC - 1));
        sa_now_o     = !din_s && !sclk_s && !lat_s;
        strap_now_o  = pad_s;
        if (st_q.cnt != CW'(BOOT_CYC)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (boot_pulse_o) begin
            st_d.standalone = sa_now_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign boot_done_o  = (st_q.cnt == CW'(BOOT_CYC));
    assign standalone_o = st_q.standalone;
endmodule

// File: rtl/ctrl_spi_frame.sv
module ctrl_spi_frame
    import ctrl_spi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             sclk_s,
    input  logic             lat_s,
    input  logic             din_s,
    input  logic [REG_W-1:0] rd_data_i,
    output logic [7:0]       rd_addr_o,
    output logic             wr_stb_o,
    output logic [7:0]       wr_addr_o,
    output logic [REG_W-1:0] wr_data_o,
    output logic             dout_o,
    output logic             oe_o
);
    typedef struct packed {
        logic                  sclk_p;
        logic                  lat_p;
        logic                  active;
        logic [FRAME_BITS-1:0] shift;
        logic [5:0]            bitcnt;
        logic                  tx_ld;
        logic                  rd_go;
        logic [REG_W-1:0]      tx;
        logic                  dout;
        logic                  oe;
        logic                  wr_stb;
        logic [7:0]            wr_addr;
        logic [REG_W-1:0]      wr_data;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic lat_fall, lat_rise, clk_rise, clk_fall;
    logic hdr_write_ok;

    always_comb begin
        st_d        = st_q;
        st_d.wr_stb = 1'b0;
        st_d.sclk_p = sclk_s;
        st_d.lat_p  = lat_s;

        lat_fall = st_q.lat_p && !lat_s;
        lat_rise = !st_q.lat_p && lat_s;
        clk_rise = !st_q.sclk_p && sclk_s;
        clk_fall = st_q.sclk_p && !sclk_s;

        hdr_write_ok = (st_q.bitcnt == 6'(FRAME_BITS))
                     && (st_q.shift[23:17] == CHIP_ID)
                     && !st_q.shift[16];

        if (!enable_i) begin
            st_d.active = 1'b0;
            st_d.oe     = 1'b0;
            st_d.rd_go  = 1'b0;
        end else if (lat_fall) begin
            st_d.active = 1'b1;
            st_d.bitcnt = '0;
            st_d.tx_ld  = 1'b0;
            st_d.rd_go  = 1'b0;
            st_d.oe     = 1'b0;
        end else if (st_q.active && lat_rise) begin
            st_d.active = 1'b0;
            st_d.oe     = 1'b0;
            st_d.rd_go  = 1'b0;
            if (hdr_write_ok) begin
                st_d.wr_stb  = 1'b1;
                st_d.wr_addr = st_q.shift[15:8];
                st_d.wr_data = st_q.shift[7:0];
            end
        end else if (st_q.active) begin
            if (clk_rise) begin
                st_d.shift = {st_q.shift[FRAME_BITS-2:0], din_s};
                if (st_q.bitcnt != 6'h3f) begin
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                end
            end
            // header complete: decide the read and fetch its data once
            if (st_q.bitcnt == 6'(HDR_BITS) && !st_q.tx_ld) begin
                st_d.tx_ld = 1'b1;
                st_d.rd_go = (st_q.shift[15:9] == CHIP_ID) && st_q.shift[8];
                st_d.tx    = rd_data_i;
            end
            if (clk_fall) begin
                if (st_q.rd_go && st_q.bitcnt >= 6'(HDR_BITS)
                    && st_q.bitcnt < 6'(FRAME_BITS)) begin
                    st_d.oe   = 1'b1;
                    st_d.dout = st_q.tx[REG_W-1];
                    st_d.tx   = {st_q.tx[REG_W-2:0], 1'b0};
                end else begin
                    st_d.oe = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sclk_p <= 1'b0;
            st_q.lat_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr_o = st_q.shift[7:0];
    assign wr_stb_o  = st_q.wr_stb;
    assign wr_addr_o = st_q.wr_addr;
    assign wr_data_o = st_q.wr_data;
    assign dout_o    = st_q.dout;
    assign oe_o      = st_q.oe;
endmodule

// File: rtl/ctrl_spi_bank.sv
module ctrl_spi_bank
    import ctrl_spi_pkg::*;
#(
    parameter int                      NREGS   = 4,
    parameter logic [NREGS*REG_W-1:0]  RST_VAL = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     boot_pulse_i,
    input  logic                     sa_now_i,
    input  logic                     strap_now_i,
    input  logic                     wr_stb_i,
    input  logic [7:0]               wr_addr_i,
    input  logic [REG_W-1:0]         wr_data_i,
    input  logic [7:0]               rd_addr_i,
    output logic [REG_W-1:0]         rd_data_o,
    output logic [NREGS*REG_W-1:0]   regs_o
);
    localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;

    typedef struct packed {
        logic [NREGS-1:0][REG_W-1:0] regs;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boot_pulse_i && sa_now_i) begin
            st_d.regs                       = RST_VAL;
            st_d.regs[CLK_REG][MCLK_BIT]    = 1'b1;
            st_d.regs[PORT_REG][MASTER_BIT] = strap_now_i;
        end else if (wr_stb_i && (wr_addr_i < 8'(NREGS))) begin
            st_d.regs[wr_addr_i[AW-1:0]] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.regs <= RST_VAL;
        else        st_q      <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i < 8'(NREGS)) begin
            rd_data_o = st_q.regs[rd_addr_i[AW-1:0]];
        end
    end

    generate
        for (genvar r = 0; r < NREGS; r++) begin : g_out
            assign regs_o[r*REG_W +: REG_W] = st_q.regs[r];
        end
    endgenerate
endmodule

// File: rtl/ctrl_spi_regport.sv
module ctrl_spi_regport
    import ctrl_spi_pkg::*;
#(
    parameter int                      NREGS       = 4,
    parameter int                      SYNC_STAGES = 2,
    parameter logic [NREGS*REG_W-1:0]  RST_VAL     = 32'h1000_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_latch_n,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    input  logic                   ser_dout_pad,
    output logic                   ser_dout,
    output logic                   ser_dout_oe,
    output logic [NREGS*REG_W-1:0] regs_o,
    output logic                   standalone_o
);
    localparam int BOOT_CYC = SYNC_STAGES + 2;

    logic [3:0]       sync_q;
    logic             lat_s, sclk_s, din_s, pad_s;
    logic             boot_pulse, boot_done, sa_now, strap_now;
    logic             wr_stb;
    logic [7:0]       wr_addr, rd_addr;
    logic [REG_W-1:0] wr_data, rd_data;

    ctrl_spi_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_dout_pad, ser_din, ser_clk, ser_latch_n}),
        .sync_o  (sync_q)
    );
    assign {pad_s, din_s, sclk_s, lat_s} = sync_q;

    ctrl_spi_strap #(.BOOT_CYC(BOOT_CYC)) u_strap (
        .clk          (clk),
        .rst_n        (rst_n),
        .din_s        (din_s),
        .sclk_s       (sclk_s),
        .lat_s        (lat_s),
        .pad_s        (pad_s),
        .boot_pulse_o (boot_pulse),
        .boot_done_o  (boot_done),
        .sa_now_o     (sa_now),
        .strap_now_o  (strap_now),
        .standalone_o (standalone_o)
    );

    ctrl_spi_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (boot_done && !standalone_o),
        .sclk_s    (sclk_s),
        .lat_s     (lat_s),
        .din_s     (din_s),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .dout_o    (ser_dout),
        .oe_o      (ser_dout_oe)
    );

    ctrl_spi_bank #(.NREGS(NREGS), .RST_VAL(RST_VAL)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_pulse_i (boot_pulse),
        .sa_now_i     (sa_now),
        .strap_now_i  (strap_now),
        .wr_stb_i     (wr_stb),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .regs_o       (regs_o)
    );
endmodule

// File: rtl/ctrl_spi_regport_chk.sv
module ctrl_spi_regport_chk #(
    parameter int NBITS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_dout_oe,
    input logic             standalone_o,
    input logic [NBITS-1:0] regs_o,
    input logic             wr_stb,
    input logic             boot_pulse,
    input logic             boot_done,
    input logic             lat_s
);
    // R1: nothing is driven before the strap sample
    p_quiet_boot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> !ser_dout_oe);

    // R5: drive only inside a frame
    p_oe_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_dout_oe |-> !$past(lat_s));

    // R7: mode frozen once sampled
    p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && $past(boot_done)) |-> $stable(standalone_o));

    // R7: forced clock enable
    p_mclk_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        standalone_o |-> regs_o[0]);

    // R8: no drive in standalone
    p_sa_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standalone_o |-> !ser_dout_oe);

    // R9: registers move only after a write or the boot sample
    p_reg_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o != $past(regs_o)) |-> ($past(wr_stb) || $past(boot_pulse)));
endmodule

bind ctrl_spi_regport ctrl_spi_regport_chk #(.NBITS(NREGS*ctrl_spi_pkg::REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_dout_oe  (ser_dout_oe),
    .standalone_o (standalone_o),
    .regs_o       (regs_o),
    .wr_stb       (wr_stb),
    .boot_pulse   (boot_pulse),
    .boot_done    (boot_done),
    .lat_s        (lat_s)
);

// File: tb/test_ctrl_spi_regport.sv
module test_ctrl_spi_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch_n = 1'b1, sclk = 1'b0, din = 1'b0, strap = 1'b0;
    logic        dout, dout_oe, standalone;
    logic [31:0] regs;
    logic        pad;

    int          n_run = 0, n_fail = 0;
    logic [7:0]  exp_q[$];
    logic [7:0]  mon_byte = '0;
    int          mon_cnt = 0;

    always #2 clk = ~clk;

    assign pad = dout_oe ? dout : strap;

    ctrl_spi_regport i_ctrl_spi_regport (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_latch_n  (latch_n),
        .ser_clk      (sclk),
        .ser_din      (din),
        .ser_dout_pad (pad),
        .ser_dout     (dout),
        .ser_dout_oe  (dout_oe),
        .regs_o       (regs),
        .standalone_o (standalone)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: collect driven bits, compare with scoreboard at latch release
    always @(posedge sclk) begin
        if (dout_oe) begin
            mon_byte = {mon_byte[6:0], dout};
            mon_cnt++;
        end
    end
    always @(negedge latch_n) mon_cnt = 0;
    always @(posedge latch_n) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(mon_cnt == 8 && mon_byte == e, "R5 read byte",
                {mon_cnt[15:0], 8'h0, mon_byte}, {16'd8, 8'h0, e});
        end else if (mon_cnt != 0) begin
            chk(1'b0, "R3/R8 unexpected drive", 32'(mon_cnt), 32'd0);
        end
    end

    task automatic do_reset(input bit sa, input logic st);
        @(negedge clk);
        rst_n = 1'b0; latch_n = sa ? 1'b0 : 1'b1; sclk = 1'b0; din = 1'b0;
        strap = st;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        latch_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic frame(input logic [23:0] w, input int nbits, input string req);
        int early = 0;
        @(negedge clk);
        latch_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            din = (i < 24) ? w[23-i] : 1'b0;
            repeat (6) @(negedge clk);
            if (i < 16 && dout_oe) early++;
            sclk = 1'b1;
            repeat (6) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        latch_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(early == 0, {req, " no drive in header"}, 32'(early), 32'd0);
        chk(dout_oe == 1'b0, {req, " released after latch"}, 32'(dout_oe), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b0, 1'b0);
        chk(regs == 32'h1000_0000, "R1 defaults", regs, 32'h1000_0000);
        chk(standalone == 1'b0, "R1 mode", 32'(standalone), 32'd0);
        chk(dout_oe == 1'b0, "R1 oe", 32'(dout_oe), 32'd0);

        // R2: write then read back
        frame(24'h08_01_A5, 24, "R2");
        chk(regs == 32'h1000_A500, "R2 write reg1", regs, 32'h1000_A500);
        exp_q.push_back(8'hA5);
        frame(24'h09_01_00, 24, "R5");
        chk(regs == 32'h1000_A500, "R5 read leaves regs", regs, 32'h1000_A500);
        exp_q.push_back(8'h10);
        frame(24'h09_03_FF, 24, "R5");

        // R3: foreign chip identity
        frame(24'h0A_00_FF, 24, "R3");
        chk(regs == 32'h1000_A500, "R3 foreign write", regs, 32'h1000_A500);
        frame(24'h0B_01_00, 24, "R3");

        // R4: wrong bit counts
        frame(24'h08_00_77, 23, "R4");
        chk(regs == 32'h1000_A500, "R4 23 bits", regs, 32'h1000_A500);
        frame(24'h08_00_77, 25, "R4");
        chk(regs == 32'h1000_A500, "R4 25 bits", regs, 32'h1000_A500);

        // R6: out-of-range address
        frame(24'h08_05_3C, 24, "R6");
        chk(regs == 32'h1000_A500, "R6 write ignored", regs, 32'h1000_A500);
        exp_q.push_back(8'h00);
        frame(24'h09_07_00, 24, "R6");

        // R2: more writes, distinct patterns
        frame(24'h08_00_3C, 24, "R2");
        frame(24'h08_02_81, 24, "R2");
        chk(regs == 32'h1081_A53C, "R2 reg0 reg2", regs, 32'h1081_A53C);
        exp_q.push_back(8'h81);
        frame(24'h09_02_00, 24, "R5");

        // R7: standalone with master strap
        do_reset(1'b1, 1'b1);
        chk(standalone == 1'b1, "R7 mode", 32'(standalone), 32'd1);
        chk(regs == 32'h1001_0001, "R7 master", regs, 32'h1001_0001);

        // R8: frames ignored in standalone
        frame(24'h08_01_55, 24, "R8");
        chk(regs == 32'h1001_0001, "R8 write ignored", regs, 32'h1001_0001);
        frame(24'h09_00_00, 24, "R8");

        // R7: standalone with slave strap
        do_reset(1'b1, 1'b0);
        chk(regs == 32'h1000_0001, "R7 slave", regs, 32'h1000_0001);

        // R1: back to normal mode
        do_reset(1'b0, 1'b1);
        chk(standalone == 1'b0 && regs == 32'h1000_0000, "R1 rereset",
            regs, 32'h1000_0000);

        chk(exp_q.size() == 0, "R5 all reads seen", 32'(exp_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule